// File: doc/BRIEF.md
# Management Bus Master with Switch Access Frames

This block is a serial management master for Ethernet PHYs and switches. It produces a management clock and drives a single bidirectional data line, which it drives from its output and enables through a separate output-enable pin. Software controls it through three registers. The data register holds the 16-bit write value, and the result of a read is placed there. The command register carries the addresses, the direction, the clock range and a start flag. The start flag also reads back as the busy indication. A one-bit control register selects the frame format.

Two frame formats exist. The standard format carries opcode 10 for a read and 01 for a write. The switch-access format sends opcode 00 in both directions and moves the direction into the top bit of the 5-bit PHY address field. That bit is 1 for a read and 0 for a write. The remaining four address bits come from the command register.

Every frame has 64 bits, sent MSB first. The frame is 32 preamble ones, start pattern 01, the 2-bit opcode, the 5-bit PHY field, the 5-bit register field, a 2-bit turnaround and 16 data bits.

Top module: `mgmt_master`

## Requirements
- R1: After reset, the command readback, the data register and the format bit are 0, the management clock is low and the data line is not driven.
- R2: A write to the command register (select 0) with bit 0 set while idle makes bit 0 read 1 from the next cycle. Bit 0 stays 1 until exactly 64 rising clock edges of the frame have occurred, and then reads 0. A command write with bit 0 clear starts nothing.
- R3: A standard write sends 32 ones, 01, opcode 01, the PHY address (command bits 15..11), the register address (command bits 10..6), turnaround 10 and the data register, MSB first. The line is driven for all 64 bits.
- R4: A standard read sends opcode 10 in its first 46 bits. The master releases the line (output-enable low) for the two turnaround bits and the 16 data bits.
- R5: During a read, the data line is sampled at the rising edges of the last 16 frame bits, MSB first. The result is in the data register (select 1) in the first cycle in which busy reads 0.
- R6: With the format bit (select 2, bit 0) at 1, the opcode is 00 and the PHY field is {direction, command bits 14..11}. The direction is 1 for a read and 0 for a write, and command bit 15 has no effect.
- R7: The management clock period is 2*(range+1)*HALF_BASE system clocks, where range is command bits 5..2 latched at start.
- R8: Within a frame, the data output and its enable change only on system clock edges where the management clock falls.
- R9: A command write while busy is ignored: the fields of the command readback and the frame in progress are unchanged.
- R10: The format bit is taken at start. Changing it during a frame does not alter that frame.
- R11: When idle after a frame, the management clock is low and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 data, 2 format |
| reg_wdata | input | 16 | Register write value |
| cmd_rd | output | 16 | Command readback, bit 0 is busy |
| data_rd | output | 16 | Data register readback |
| alt_rd | output | 1 | Format bit readback (1 = switch-access) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
Busy is due one system clock after the command write. The bench samples it at the next falling system edge. Frame bits and enables are captured at each management clock rise, which is where the far end samples them. The bench checks the clock period between consecutive rises against 2*(range+1)*HALF_BASE. The bench responder drives read data just after each management clock fall, so the data is stable for the next rise. The read result and the bit count are checked in the very first sample where busy reads 0, which is the cycle R5 promises.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(FRAME_BITS - 18);
    localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(FRAME_BITS - 16);

    // command register layout (bit 0 is the start/busy flag)
    typedef struct packed {
        logic [4:0] phy;
        logic [4:0] regad;
        logic [3:0] clk_sel;
        logic       wr;
        logic       go;
    } mgmt_cmd_t;

    typedef enum logic {FMT_STD = 1'b0, FMT_ALT = 1'b1} frame_fmt_e;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2
    } reg_sel_e;

    function automatic logic [1:0] opcode_of(frame_fmt_e fmt, logic wr);
        if (fmt == FMT_ALT) return 2'b00;
        return wr ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [4:0] phy_field(frame_fmt_e fmt, logic wr, logic [4:0] phy);
        if (fmt == FMT_ALT) return {~wr, phy[3:0]};
        return phy;
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(mgmt_cmd_t c, frame_fmt_e fmt,
                                                          logic [15:0] d);
        return {{PRE_BITS{1'b1}}, 2'b01, opcode_of(fmt, c.wr),
                phy_field(fmt, c.wr, c.phy), c.regad, 2'b10, d};
    endfunction

endpackage

// File: rtl/mgmt_clkdiv.sv
module mgmt_clkdiv #(
    parameter int HALF_BASE = 2,
    parameter int SEL_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    localparam int MAX_HALF = (1 << SEL_W) * HALF_BASE;
    localparam int CNT_W    = $clog2(MAX_HALF + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;
    logic             wrap;

    always_comb begin
        half_m1   = CNT_W'((int'(sel) + 1) * HALF_BASE - 1);
        wrap      = run && (cnt == half_m1);
        rise_tick = wrap && !mdc;
        fall_tick = wrap && mdc;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mgmt_seq.sv
module mgmt_seq
    import mgmt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  is_read,
    input  logic                  rise_tick,
    input  logic                  fall_tick,
    input  logic                  mdio_i,
    output logic                  busy,
    output logic                  done,
    output logic                  rd_txn,
    output logic [IDX_W-1:0]      bit_idx,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic [15:0]           rx_data
);
    logic [FRAME_BITS-1:0] sh;

    always_comb begin
        done    = busy && fall_tick && (bit_idx == IDX_LAST);
        mdio_o  = busy ? sh[FRAME_BITS-1] : 1'b1;
        mdio_oe = busy && (!rd_txn || (bit_idx < IDX_TA));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            rd_txn  <= 1'b0;
            bit_idx <= '0;
            sh      <= '0;
            rx_data <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            rd_txn  <= is_read;
            bit_idx <= '0;
            sh      <= frame;
        end else if (busy) begin
            if (fall_tick) begin
                if (done) begin
                    busy <= 1'b0;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                    sh      <= {sh[FRAME_BITS-2:0], 1'b0};
                end
            end
            if (rise_tick && rd_txn && (bit_idx >= IDX_DATA)) begin
                rx_data <= {rx_data[14:0], mdio_i};
            end
        end
    end
endmodule

// File: rtl/mgmt_master.sv
module mgmt_master
    import mgmt_pkg::*;
#(
    parameter int HALF_BASE = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] cmd_rd,
    output logic [15:0] data_rd,
    output logic        alt_rd,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mgmt_cmd_t             cmd_in;
    logic [15:1]           cmd_fields;
    logic [15:0]           data_q;
    frame_fmt_e            fmt_q;
    logic                  wr_cmd;
    logic                  start;
    logic [FRAME_BITS-1:0] frame;
    logic                  busy;
    logic                  done;
    logic                  rd_txn;
    logic [IDX_W-1:0]      bit_idx;
    logic [15:0]           rx_data;
    logic                  rise_tick;
    logic                  fall_tick;

    always_comb begin
        cmd_in  = mgmt_cmd_t'(reg_wdata);
        wr_cmd  = reg_wr && (reg_sel == SEL_CMD);
        start   = wr_cmd && cmd_in.go && !busy;
        frame   = build_frame(cmd_in, fmt_q, data_q);
        cmd_rd  = {cmd_fields, busy};
        data_rd = data_q;
        alt_rd  = (fmt_q == FMT_ALT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_fields <= '0;
            data_q     <= '0;
            fmt_q      <= FMT_STD;
        end else begin
            if (wr_cmd && !busy) begin
                cmd_fields <= reg_wdata[15:1];
            end
            if (done && rd_txn) begin
                data_q <= rx_data;
            end else if (reg_wr && (reg_sel == SEL_DATA) && !busy) begin
                data_q <= reg_wdata;
            end
            if (reg_wr && (reg_sel == SEL_CTRL)) begin
                fmt_q <= frame_fmt_e'(reg_wdata[0]);
            end
        end
    end

    mgmt_clkdiv #(
        .HALF_BASE (HALF_BASE),
        .SEL_W     (4)
    ) clkdiv_i (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .sel       (cmd_fields[5:2]),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mgmt_seq seq_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .frame     (frame),
        .is_read   (!cmd_in.wr),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .done      (done),
        .rd_txn    (rd_txn),
        .bit_idx   (bit_idx),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rx_data   (rx_data)
    );
endmodule

// File: rtl/mgmt_master_chk.sv
module mgmt_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [1:0]  reg_sel,
    input logic        go_bit,
    input logic        busy,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        rd_txn,
    input logic [5:0]  bit_idx,
    input logic [15:0] cmd_rd
);
    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && reg_wr && reg_sel == 2'd0 && go_bit) |=> busy);

    // R2
    frame_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(mdc) && !mdc));

    // R9
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cmd_rd[15:1]));

    // R8
    mdio_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !($past(mdc) && !mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R4
    read_release_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_txn && bit_idx >= 6'd46) |-> !mdio_oe);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));
endmodule

bind mgmt_master mgmt_master_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .reg_wr  (reg_wr),
    .reg_sel (reg_sel),
    .go_bit  (reg_wdata[0]),
    .busy    (busy),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rd_txn  (rd_txn),
    .bit_idx (bit_idx),
    .cmd_rd  (cmd_rd)
);

// File: tb/mgmt_master_tb_top.sv
module mgmt_master_tb_top;
    localparam int HB = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic        mdio_i = 1'b1;
    logic [15:0] cmd_rd, data_rd;
    logic        alt_rd, mdc, mdio_o, mdio_oe;

    always #4 clk = ~clk;

    mgmt_master #(.HALF_BASE(HB)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cmd_rd(cmd_rd), .data_rd(data_rd),
        .alt_rd(alt_rd), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int nbits = 0;
    int last_rise = 0;
    int exp_half = 1;
    int period_err = 0;
    int glitch = 0;
    logic [63:0] cap_bits = '0;
    logic [63:0] cap_oe = '0;
    logic [15:0] resp = '0;
    logic pm = 1'b0, po = 1'b1, pb = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (cmd_rd[0] && pb && !(pm && !mdc) && (mdio_o !== po || mdio_oe !== pm_oe))
            glitch++;
        pm = mdc;
        po = mdio_o;
        pb = cmd_rd[0];
        pm_oe = mdio_oe;
    end
    logic pm_oe = 1'b0;

    // capture each bit at the management clock rise, like the far end
    always @(posedge mdc) begin
        if (nbits < 64) begin
            cap_bits[63-nbits] = mdio_o;
            cap_oe[63-nbits]   = mdio_oe;
        end
        if (nbits > 0 && (cyc - last_rise) != 2 * exp_half) period_err++;
        last_rise = cyc;
        nbits++;
    end

    // responder: put read data on the line after each fall
    always @(negedge mdc) begin
        if (nbits >= 48 && nbits < 64) mdio_i = resp[63-nbits];
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_sel = sel;
        reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic xfer(input bit alt, input bit wr, input logic [4:0] phy,
                        input logic [4:0] regad, input logic [3:0] sel,
                        input logic [15:0] wd, input logic [15:0] rs, input bit inject);
        logic [1:0]  op;
        logic [4:0]  pf;
        logic [63:0] ef;
        logic [15:1] fields;
        int n;
        string ftag;
        wreg(2'd2, {15'd0, alt});
        chk(alt_rd == alt, "R10 format readback", 64'(alt_rd), 64'(alt));
        if (wr) wreg(2'd1, wd);
        resp = rs;
        nbits = 0;
        period_err = 0;
        glitch = 0;
        exp_half = (int'(sel) + 1) * HB;
        fields = {phy, regad, sel, wr};
        wreg(2'd0, {fields, 1'b1});
        chk(cmd_rd[0] == 1'b1, "R2 busy after start", 64'(cmd_rd), 64'({fields, 1'b1}));
        if (inject) begin
            repeat (40) @(negedge clk);
            wreg(2'd0, {~fields, 1'b1});
            wreg(2'd2, {15'd0, ~alt});
            chk(cmd_rd[15:1] == fields, "R9 fields while busy", 64'(cmd_rd[15:1]), 64'(fields));
        end
        n = 0;
        while (cmd_rd[0] && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (!wr) chk(data_rd == rs, "R5 read data at busy clear", 64'(data_rd), 64'(rs));
        else chk(data_rd == wd, "R3 data register kept", 64'(data_rd), 64'(wd));
        chk(nbits == 64, "R2 64 rises per frame", 64'(nbits), 64'd64);
        op = alt ? 2'b00 : (wr ? 2'b01 : 2'b10);
        pf = alt ? {~wr, phy[3:0]} : phy;
        ef = {32'hFFFF_FFFF, 2'b01, op, pf, regad, 2'b10, (wr ? wd : 16'h0000)};
        ftag = alt ? (inject ? "R6 R10 frame" : "R6 frame")
                   : (inject ? "R3 R4 R10 frame" : (wr ? "R3 frame" : "R4 frame"));
        if (wr) begin
            chk(cap_bits == ef, ftag, cap_bits, ef);
            chk(cap_oe == '1, "R3 enable all bits", cap_oe, '1);
        end else begin
            chk(cap_bits[63:18] == ef[63:18], ftag, 64'(cap_bits[63:18]), 64'(ef[63:18]));
            chk(cap_oe[63:18] == '1 && cap_oe[17:0] == '0, "R4 release",
                cap_oe, {46'h3FFF_FFFF_FFFF, 18'h0});
        end
        chk(period_err == 0, "R7 clock period", 64'(period_err), 64'd0);
        chk(glitch == 0, "R8 change on fall only", 64'(glitch), 64'd0);
        chk(!mdc && !mdio_oe, "R11 idle quiet", {62'd0, mdc, mdio_oe}, 64'd0);
        chk(cmd_rd[15:1] == fields, "R9 fields kept", 64'(cmd_rd[15:1]), 64'(fields));
    endtask

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_rd == 16'd0, "R1 command reset", 64'(cmd_rd), 64'd0);
        chk(data_rd == 16'd0, "R1 data reset", 64'(data_rd), 64'd0);
        chk(alt_rd == 1'b0, "R1 format reset", 64'(alt_rd), 64'd0);
        chk(!mdc && !mdio_oe, "R1 bus idle", {62'd0, mdc, mdio_oe}, 64'd0);

        // command write without start flag
        wreg(2'd0, 16'hA5A4);
        repeat (10) @(negedge clk);
        chk(cmd_rd == 16'hA5A4, "R2 no start without flag", 64'(cmd_rd), 64'hA5A4);
        chk(!mdc, "R2 clock stays low", 64'(mdc), 64'd0);

        for (int a = 0; a < 2; a++) begin
            for (int w = 0; w < 2; w++) begin
                for (int s = 0; s < 4; s++) begin
                    int idx;
                    idx = a * 8 + w * 4 + s;
                    xfer(a[0], w[0], 5'(idx * 7 + 17), 5'(idx * 11 + 3), 4'(s),
                         16'((idx * 16'h1357) ^ 16'hA5C3),
                         16'((idx * 16'h2468) ^ 16'h5A3C), (s == 1));
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule